// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control half of an eight-channel, single-result converter. Software sees it as two 32-bit registers on a register bus: a control word and a read-only result word. The analog front end is represented by eight digital sample inputs and two reference values: one internal, one external. Software picks a channel, a reference and a clock divider, enables the block and sets a convert bit. The block then times a conversion window whose length follows from the divider. It scales the chosen sample against the chosen reference and saturates the quotient to 10 bits. At the end of the window it writes the result, drops the convert bit and, if enabled, raises a sticky interrupt.

The register bus is a plain single-cycle interface. A write is taken on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` and is always ready, so there is no valid/ready pairing and no back-pressure. The block never stalls the bus. A soft-reset bit inside the control word gives software the same effect as the reset pin.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control word reads 0x000C0001, the result word reads 0 and `irq` is low.
- R2: Address 0x0 reads the control word and address 0x4 reads the result in bits 9:0, with upper bits zero. Any other address reads zero. A write to 0x4 has no effect.
- R3: A conversion starts only on a control write that has enable (bit 17) set and moves convert (bit 14) from 0 to 1. The result appears on the clock edge exactly 40 × (divider + 1) cycles after the write edge, where divider is bits 8:1. Until then, bit 14 reads 1.
- R4: The result is min(1023, sample × 1024 / reference). Reference select (bit 19) at 1 picks the internal reference and at 0 the external one. A zero reference gives 1023. The channel (bits 27:24), the sample and the reference are captured when the conversion starts.
- R5: A completed conversion clears bit 14. If interrupt enable (bit 21) is set, it also sets the flag (bit 18) and drives `irq` high.
- R6: Writing 1 to bit 18 clears the flag and lowers `irq`. Writing 0 to bit 18 leaves the flag and `irq` as they were.
- R7: A control write with enable set and convert at 0 cancels a running conversion. The result and `irq` stay unchanged afterwards.
- R8: A control write with bit 16 set acts as a full reset: the control word becomes 0x000C0001, the result becomes 0, `irq` drops and any running conversion is cancelled. The other bits of that write are ignored.
- R9: When the captured channel is 8 or higher, the end of the window leaves the result, the flag, `irq` and bit 14 unchanged.
- R10: A control write that sets convert while enable is 0 starts no conversion. The result stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| smp_bus | input | 128 | Eight 16-bit channel samples, channel 0 in the lowest bits |
| ref_int | input | 16 | Internal reference value |
| ref_ext | input | 16 | External reference value |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
A wrong window count shows as bit 14 clearing one cycle early or late, so the bench samples bit 14 exactly one cycle before and one cycle after the computed edge. An error in the divider's shift-subtract state shows only in the final result value. For that reason the vectors include exact quotients, a value just under the reference, a value at the reference, a zero reference and a near-zero quotient. A stale channel latch, a flag that survives a write of 1, or a cancel that fails to stop the timer each appear within one window as an unexpected result or `irq` level.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_LO    = 24;
  localparam int CH_W     = 4;
  localparam int B_INTEN  = 21;
  localparam int B_REFSEL = 19;
  localparam int B_FLAG   = 18;
  localparam int B_EN     = 17;
  localparam int B_SRST   = 16;
  localparam int B_CONV   = 14;
  localparam int DIV_LO   = 1;
  localparam int DIV_W    = 8;
  localparam int RES_W    = 10;
  localparam logic [31:0] CTL_RESET = 32'h000C_0001;
endpackage

// File: rtl/adc_win_timer.sv
module adc_win_timer #(
  parameter int DIV_W    = 8,
  parameter int CONV_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             fire
);
  localparam int MAXN  = CONV_CYC * 2 * (1 << DIV_W);
  localparam int CNT_W = $clog2(MAXN) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(CONV_CYC * 2) * (CNT_W'(div) + CNT_W'(1)) - CNT_W'(1);
  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (cancel) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !busy); // R7
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cancel) |=> (busy && !fire)); // R3
endmodule

// File: rtl/adc_scale_div.sv
module adc_scale_div #(
  parameter int SMP_W = 16,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] dref,
  output logic             done,
  output logic [RES_W-1:0] quo
);
  localparam int STEP_W = $clog2(RES_W + 1);

  logic [SMP_W-1:0]  rem;
  logic [SMP_W-1:0]  den;
  logic [STEP_W-1:0] steps;
  logic              run;
  logic [SMP_W:0]    dbl;
  logic [SMP_W:0]    diff;

  assign dbl  = {rem, 1'b0};
  assign diff = dbl - {1'b0, den};
  assign done = !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      rem   <= '0;
      den   <= '0;
      steps <= '0;
      quo   <= '0;
    end else if (start) begin
      den <= dref;
      if (smp >= dref) begin
        quo <= '1;
        run <= 1'b0;
      end else begin
        rem   <= smp;
        quo   <= '0;
        steps <= STEP_W'(RES_W);
        run   <= 1'b1;
      end
    end else if (run) begin
      if (dbl >= {1'b0, den}) begin
        rem <= diff[SMP_W-1:0];
        quo <= {quo[RES_W-2:0], 1'b1};
      end else begin
        rem <= dbl[SMP_W-1:0];
        quo <= {quo[RES_W-2:0], 1'b0};
      end
      steps <= steps - STEP_W'(1);
      run   <= (steps != STEP_W'(1));
    end
  end

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && smp >= dref) |=> (done && quo == '1)); // R4
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [31:0]      wdata,
  input  logic             fire,
  input  logic [RES_W-1:0] res,
  output logic [31:0]      ctl,
  output logic [RES_W-1:0] data,
  output logic             irq,
  output logic             start,
  output logic             cancel,
  output logic             soft_rst
);
  logic        ch_ok;
  logic        commit;
  logic [31:0] ctl_cmp;
  logic [31:0] ctl_nxt;
  logic        irq_cmp;
  logic        irq_nxt;
  logic        plain_wr;

  assign soft_rst = wr_ctl && wdata[B_SRST];
  assign plain_wr = wr_ctl && !wdata[B_SRST];
  assign start    = plain_wr && wdata[B_EN] && wdata[B_CONV] && !ctl[B_CONV];
  assign cancel   = soft_rst || (plain_wr && wdata[B_EN] && !wdata[B_CONV]);
  assign commit   = fire && ch_ok;

  always_comb begin
    ctl_cmp = ctl;
    irq_cmp = irq;
    if (commit) begin
      ctl_cmp[B_CONV] = 1'b0;
      if (ctl[B_INTEN]) begin
        ctl_cmp[B_FLAG] = 1'b1;
        irq_cmp         = 1'b1;
      end
    end
    ctl_nxt = ctl_cmp;
    irq_nxt = irq_cmp;
    if (plain_wr) begin
      ctl_nxt = wdata;
      if (wdata[B_FLAG]) begin
        ctl_nxt[B_FLAG] = 1'b0;
        irq_nxt         = 1'b0;
      end else begin
        ctl_nxt[B_FLAG] = ctl_cmp[B_FLAG];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= CTL_RESET;
      data  <= '0;
      irq   <= 1'b0;
      ch_ok <= 1'b0;
    end else if (soft_rst) begin
      ctl   <= CTL_RESET;
      data  <= '0;
      irq   <= 1'b0;
      ch_ok <= 1'b0;
    end else begin
      ctl <= ctl_nxt;
      irq <= irq_nxt;
      if (commit) data <= res;
      if (start) ch_ok <= (32'(wdata[CH_LO +: CH_W]) < NUM_CH);
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl[B_FLAG]); // R6
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl == CTL_RESET && data == '0 && !irq)); // R8
  AST_CONV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_ctl) |=> !ctl[B_CONV]); // R5
  AST_BAD_CH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ch_ok && !wr_ctl) |=> ($stable(data) && $stable(irq) && ctl[B_CONV])); // R9
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SMP_W    = 16,
  parameter int ADDR_W   = 12,
  parameter int CONV_CYC = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_CH*SMP_W-1:0] smp_bus,
  input  logic [SMP_W-1:0]        ref_int,
  input  logic [SMP_W-1:0]        ref_ext,
  output logic                    irq
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(4);

  logic             wr_ctl;
  logic [31:0]      ctl;
  logic [RES_W-1:0] data;
  logic [RES_W-1:0] quo;
  logic             div_done;
  logic             start;
  logic             cancel;
  logic             soft_rst;
  logic             busy;
  logic             fire;
  logic [SMP_W-1:0] smp_sel;
  logic [SMP_W-1:0] ref_sel;
  logic [CH_W-1:0]  ch_w;

  assign wr_ctl  = bus_wr && (bus_addr == A_CTL);
  assign ch_w    = bus_wdata[CH_LO +: CH_W];
  assign ref_sel = bus_wdata[B_REFSEL] ? ref_int : ref_ext;

  always_comb begin
    smp_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (32'(ch_w) == i) smp_sel = smp_bus[i*SMP_W +: SMP_W];
  end

  always_comb begin
    if (bus_addr == A_CTL)       bus_rdata = ctl;
    else if (bus_addr == A_DATA) bus_rdata = 32'(data);
    else                         bus_rdata = '0;
  end

  adc_ctl_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(bus_wdata),
    .fire(fire), .res(quo), .ctl(ctl), .data(data), .irq(irq),
    .start(start), .cancel(cancel), .soft_rst(soft_rst)
  );

  adc_win_timer #(.DIV_W(DIV_W), .CONV_CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
    .div(bus_wdata[DIV_LO +: DIV_W]), .busy(busy), .fire(fire)
  );

  adc_scale_div #(.SMP_W(SMP_W), .RES_W(RES_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .smp(smp_sel),
    .dref(ref_sel), .done(div_done), .quo(quo)
  );

  AST_DIV_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> div_done); // R4
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !bus_wdata[B_EN] && !busy) |=> !busy); // R10
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int NCH = 8;
  localparam int SW  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH*SW-1:0] smp_bus = '0;
  logic [SW-1:0]   ref_int = '0;
  logic [SW-1:0]   ref_ext = '0;
  logic            irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_bus(smp_bus),
    .ref_int(ref_int), .ref_ext(ref_ext), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  ch;
    logic        rsel;
    logic [7:0]  div;
    logic [15:0] smp;
    logic [15:0] rf;
    logic [9:0]  exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd0, 1'b0, 8'd0, 16'd500,  16'd1000,  10'd512},
    '{4'd3, 1'b1, 8'd1, 16'd1500, 16'd2000,  10'd768},
    '{4'd7, 1'b0, 8'd2, 16'd299,  16'd300,   10'd1020},
    '{4'd5, 1'b1, 8'd0, 16'd100,  16'd100,   10'd1023},
    '{4'd1, 1'b0, 8'd0, 16'd5,    16'd0,     10'd1023},
    '{4'd2, 1'b1, 8'd0, 16'd1,    16'd65535, 10'd0},
    '{4'd6, 1'b0, 8'd3, 16'd1023, 16'd1024,  10'd1023}
  };

  localparam logic [31:0] EN = 32'h0002_0000;
  localparam logic [31:0] CV = 32'h0000_4000;
  localparam logic [31:0] IE = 32'h0020_0000;
  localparam logic [31:0] FL = 32'h0004_0000;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] cw;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(12'h0, r); check("R1 ctl", r, 32'h000C_0001);
    rd(12'h4, r); check("R1 data", r, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 unmapped and read-only
    rd(12'h8, r); check("R2 unmapped", r, 32'h0);
    wr(12'h4, 32'hFFFF_FFFF);
    rd(12'h4, r); check("R2 data ro", r, 32'h0);

    // Vector table: R3 timing, R4 scaling, R5 completion
    foreach (VECS[i]) begin
      smp_bus = '0;
      smp_bus[VECS[i].ch*SW +: SW] = VECS[i].smp;
      if (VECS[i].rsel) begin ref_int = VECS[i].rf; ref_ext = 16'h7; end
      else begin ref_ext = VECS[i].rf; ref_int = 16'h7; end
      cw = EN | CV | IE | FL | (32'(VECS[i].ch) << 24) | (32'(VECS[i].rsel) << 19)
         | (32'(VECS[i].div) << 1);
      n = 40 * (int'(VECS[i].div) + 1);
      wr(12'h0, cw);
      smp_bus = '1; ref_int = 16'h1; ref_ext = 16'h1;
      cycles(n - 1);
      check("R3 busy before end", {31'b0, bus_rdata_ctl_conv()}, 32'h1);
      check("R5 irq low before end", {31'b0, irq}, 32'h0);
      cycles(1);
      check("R3 conv cleared at end", {31'b0, bus_rdata_ctl_conv()}, 32'h0);
      rd(12'h4, r); check("R4 result", r, 32'(VECS[i].exp));
      check("R5 irq raised", {31'b0, irq}, 32'h1);
      rd(12'h0, r); check("R5 flag set", {31'b0, r[18]}, 32'h1);
    end

    // R6 write 0 keeps flag, write 1 clears
    wr(12'h0, EN | IE);
    rd(12'h0, r); check("R6 flag kept", {31'b0, r[18]}, 32'h1);
    check("R6 irq kept", {31'b0, irq}, 32'h1);
    wr(12'h0, EN | IE | FL);
    rd(12'h0, r); check("R6 flag cleared", {31'b0, r[18]}, 32'h0);
    check("R6 irq cleared", {31'b0, irq}, 32'h0);

    // R7 cancel
    smp_bus = '0; smp_bus[0 +: SW] = 16'd10; ref_ext = 16'd20;
    wr(12'h0, EN | CV | IE);
    cycles(10);
    wr(12'h0, EN | IE);
    cycles(60);
    rd(12'h4, r); check("R7 data unchanged", r, 32'h3FF);
    check("R7 irq low", {31'b0, irq}, 32'h0);

    // R10 no start while disabled
    wr(12'h0, CV | IE);
    cycles(60);
    rd(12'h4, r); check("R10 data unchanged", r, 32'h3FF);
    check("R10 irq low", {31'b0, irq}, 32'h0);
    wr(12'h0, EN | IE);

    // R9 channel out of range
    wr(12'h0, EN | CV | IE | (32'd9 << 24));
    cycles(60);
    rd(12'h4, r); check("R9 data unchanged", r, 32'h3FF);
    rd(12'h0, r); check("R9 conv stays", {31'b0, r[14]}, 32'h1);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    wr(12'h0, EN | IE);

    // R8 soft reset
    wr(12'h0, EN | CV | IE);
    cycles(5);
    wr(12'h0, 32'h0F2F_41FE | 32'h0001_0000);
    rd(12'h0, r); check("R8 ctl", r, 32'h000C_0001);
    rd(12'h4, r); check("R8 data", r, 32'h0);
    cycles(60);
    rd(12'h4, r); check("R8 cancelled", r, 32'h0);
    check("R8 irq", {31'b0, irq}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic bus_rdata_ctl_conv();
    return (bus_addr == 12'h0) ? bus_rdata[14] : 1'bx;
  endfunction
endmodule